// File: doc/BRIEF.md
# Audio-Visual Container Demultiplexer

This block sits behind a frame filter and takes the 32-bit payload words of accepted frames as one continuous stream. The stream is a chain of audio-visual containers. Each container starts with a one-word header that gives its kind, a running index and a byte length. The payload follows in whole words. A container may cross any number of frame boundaries, and gaps in the input stream have no effect on parsing.

Video containers are turned into a pixel stream that carries one pixel per handshake. A configuration input selects one byte or three bytes per pixel, so the block repacks bytes across word boundaries. Ancillary containers pass through as 32-bit words. A byte-enable mask and an end marker show where the last, possibly partial, word of each object ends. Containers of any other kind are consumed without output and raise a sticky error flag. A second sticky flag reports a break in the index sequence. Backpressure on either output stalls the input side, and no data is lost.

Top module: `avc_demux`

## Requirements
- R1: A header is one word: kind in bits [7:0], index in bits [15:8], byte length in bits [31:16]. The payload takes the next ceil(length/4) words and the word after that is the next header, whatever the kind, length or input gaps. A length of 0 means no payload words.
- R2: Kind 0x01 is video and goes only to the vid_* port. Kind 0x02 is ancillary and goes only to the anc_* port. The two valid outputs are never high together.
- R3: When cfg_pix3 is 0 at header time, each payload byte becomes one pixel, zero-extended to 24 bits, in stream order.
- R4: When cfg_pix3 is 1 at header time, each pixel is three consecutive bytes with the earliest byte in bits [7:0]. A container yields floor(length/3) pixels, and the 0 to 2 leftover bytes are dropped.
- R5: vid_last is high on the final pixel of each video container and low on every other pixel.
- R6: Each ancillary payload word appears unchanged on anc_data, and anc_last marks the final word. anc_be bit i flags byte i (bits [8i+7:8i]) as valid. It is 4'hF on every word except the final one, which has its low (length mod 4) bits set, or 4'hF when that is 0.
- R7: A container of any other kind has its payload consumed with no output on either port, and err_kind is set and stays set until reset.
- R8: From the second header after reset on, an index that is not the previous header's index plus one (modulo 256) sets err_seq, which stays set until reset. Skipped containers count in this sequence.
- R9: While vid_valid is high and vid_ready is low, the pixel and vid_last hold their values. Stalls on either output stop input intake and lose no data.
- R10: While rst_n is low, both valid outputs and both error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pix3 | input | 1 | 1 selects three bytes per pixel, 0 selects one byte; sampled at each header |
| in_valid | input | 1 | Payload word valid |
| in_ready | output | 1 | Payload word accepted when high together with in_valid |
| in_data | input | 32 | Payload word |
| vid_valid | output | 1 | Pixel valid |
| vid_ready | input | 1 | Pixel sink ready |
| vid_pixel | output | 24 | Pixel value |
| vid_last | output | 1 | Final pixel of the container |
| anc_valid | output | 1 | Ancillary word valid |
| anc_ready | input | 1 | Ancillary sink ready |
| anc_data | output | 32 | Ancillary word |
| anc_be | output | 4 | Valid bytes of the ancillary word |
| anc_last | output | 1 | Final word of the ancillary object |
| err_kind | output | 1 | Sticky: a container of unknown kind was seen |
| err_seq | output | 1 | Sticky: a container index broke the sequence |

## Verification
Video is tried at both pixel widths with lengths that are multiples of three, lengths that leave one or two bytes over, and a length shorter than one pixel. These cases show whether bytes carried between words land in the right pixel and whether the container end and vid_last agree. Ancillary lengths of 1, 7, 8 and 30 cover every remainder of the byte-enable mask. Long containers are then run under random input gaps and random stalls on both outputs, which shows whether a stall loses, repeats or reorders data. A container of unknown kind, an index gap and an index wrap from 0xFF to 0x00 check the error flags, and a video container sent after the skipped one shows that framing has recovered.

// File: rtl/avc_pkg.sv
package avc_pkg;

  localparam int WORD_W   = 32;
  localparam int WORD_B   = WORD_W / 8;
  localparam int PIX_W    = 24;
  localparam int ACC_B    = 6;
  localparam int ACC_W    = ACC_B * 8;
  localparam int LEN_W    = 16;
  localparam int IDX_W    = 8;
  localparam int KIND_W   = 8;

  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_VID  = 2'd1,
    ST_ANC  = 2'd2,
    ST_SKIP = 2'd3
  } avc_state_e;

  // header word: length in the top half, index, then kind in the low byte
  typedef struct packed {
    logic [LEN_W-1:0]  len;
    logic [IDX_W-1:0]  idx;
    logic [KIND_W-1:0] kind;
  } avc_hdr_t;

  function automatic logic [WORD_B-1:0] lane_mask(input logic [2:0] nbytes);
    logic [WORD_B-1:0] m;
    for (int i = 0; i < WORD_B; i++) begin
      m[i] = (3'(i) < nbytes);
    end
    return m;
  endfunction

endpackage

// File: rtl/avc_rst_sync.sv
module avc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_core_n = chain_q[STAGES-1];

endmodule

// File: rtl/avc_pix_pack.sv
module avc_pix_pack
  import avc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic [2:0]        nb,
  input  logic              pop,
  input  logic              pix3,
  output logic [2:0]        cnt,
  output logic [PIX_W-1:0]  pixel
);

  logic [ACC_W-1:0]  acc_q, acc_d, shifted, ins;
  logic [2:0]        cnt_q, cnt_d, cnt_s;
  logic [WORD_W-1:0] masked;
  logic [WORD_B-1:0] lanes;
  logic              en;

  assign lanes = lane_mask(nb);

  generate
    for (genvar g = 0; g < WORD_B; g++) begin : g_lane
      assign masked[g*8 +: 8] = lanes[g] ? word[g*8 +: 8] : 8'h00;
    end
  endgenerate

  always_comb begin
    if (pop) begin
      shifted = pix3 ? (acc_q >> 24) : (acc_q >> 8);
      cnt_s   = cnt_q - (pix3 ? 3'd3 : 3'd1);
    end else begin
      shifted = acc_q;
      cnt_s   = cnt_q;
    end
    ins = {{(ACC_W-WORD_W){1'b0}}, masked} << {cnt_s, 3'b000};
    if (clr) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (load) begin
      acc_d = shifted | ins;
      cnt_d = cnt_s + nb;
    end else begin
      acc_d = shifted;
      cnt_d = cnt_s;
    end
  end

  assign en = clr | load | pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt   = cnt_q;
  assign pixel = pix3 ? acc_q[23:0] : {16'h0000, acc_q[7:0]};

endmodule

// File: rtl/avc_seq_check.sv
module avc_seq_check
  import avc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_fire,
  input  logic [IDX_W-1:0] idx,
  input  logic             kind_bad,
  output logic             err_kind,
  output logic             err_seq
);

  logic             seen_q, seen_d;
  logic [IDX_W-1:0] prev_q, prev_d;
  logic             ek_q, ek_d, es_q, es_d;

  always_comb begin
    seen_d = seen_q;
    prev_d = prev_q;
    ek_d   = ek_q;
    es_d   = es_q;
    if (hdr_fire) begin
      seen_d = 1'b1;
      prev_d = idx;
      if (seen_q && (idx != prev_q + 1'b1)) es_d = 1'b1;
      if (kind_bad) ek_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      prev_q <= '0;
      ek_q   <= 1'b0;
      es_q   <= 1'b0;
    end else if (hdr_fire) begin
      seen_q <= seen_d;
      prev_q <= prev_d;
      ek_q   <= ek_d;
      es_q   <= es_d;
    end
  end

  assign err_kind = ek_q;
  assign err_seq  = es_q;

endmodule

// File: rtl/avc_demux.sv
module avc_demux
  import avc_pkg::*;
#(
  parameter logic [7:0] KIND_VIDEO  = 8'h01,
  parameter logic [7:0] KIND_ANC    = 8'h02,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_pix3,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  output logic        vid_valid,
  input  logic        vid_ready,
  output logic [23:0] vid_pixel,
  output logic        vid_last,
  output logic        anc_valid,
  input  logic        anc_ready,
  output logic [31:0] anc_data,
  output logic [3:0]  anc_be,
  output logic        anc_last,
  output logic        err_kind,
  output logic        err_seq
);

  localparam int PAD_B = LEN_W - 3;

  logic             rst_core_n;
  avc_state_e       state_q, state_d;
  logic [LEN_W-1:0] in_left_q, in_left_d;
  logic [LEN_W-1:0] out_left_q, out_left_d;
  logic             pix3_q, pix3_d;
  avc_hdr_t         hdr;
  logic [2:0]       nb, pb, pb_new, cnt, cnt_after;
  logic [LEN_W-1:0] nb_w, pb_w, pb2_w;
  logic             in_fire, vid_fire, word_last, hdr_fire, kind_bad;
  logic             pack_load, pack_clr;
  logic             en;

  avc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  assign hdr       = avc_hdr_t'(in_data);
  assign nb        = (in_left_q >= LEN_W'(WORD_B)) ? 3'(WORD_B) : in_left_q[2:0];
  assign nb_w      = {{PAD_B{1'b0}}, nb};
  assign pb        = pix3_q   ? 3'd3 : 3'd1;
  assign pb_new    = cfg_pix3 ? 3'd3 : 3'd1;
  assign pb_w      = {{PAD_B{1'b0}}, pb};
  assign pb2_w     = {{(PAD_B-1){1'b0}}, pb, 1'b0};
  assign word_last = (in_left_q <= LEN_W'(WORD_B));

  // handshakes and output decode
  always_comb begin
    vid_valid = (state_q == ST_VID) && (cnt >= pb);
    vid_fire  = vid_valid && vid_ready;
    vid_last  = vid_valid && (out_left_q < pb2_w);
    cnt_after = vid_fire ? (cnt - pb) : cnt;
    unique case (state_q)
      ST_HDR:  in_ready = 1'b1;
      ST_SKIP: in_ready = 1'b1;
      ST_ANC:  in_ready = anc_ready;
      ST_VID:  in_ready = (in_left_q != '0) && (cnt_after <= 3'd2);
      default: in_ready = 1'b0;
    endcase
    in_fire   = in_valid && in_ready;
    anc_valid = (state_q == ST_ANC) && in_valid;
    anc_data  = in_data;
    anc_be    = lane_mask(nb);
    anc_last  = anc_valid && word_last;
  end

  assign hdr_fire  = (state_q == ST_HDR) && in_fire;
  assign kind_bad  = (hdr.kind != KIND_VIDEO) && (hdr.kind != KIND_ANC);
  assign pack_load = (state_q == ST_VID) && in_fire;
  assign pack_clr  = vid_fire && vid_last;

  // next-state logic
  always_comb begin
    state_d    = state_q;
    in_left_d  = in_left_q;
    out_left_d = out_left_q;
    pix3_d     = pix3_q;
    unique case (state_q)
      ST_HDR: begin
        if (in_fire) begin
          in_left_d  = hdr.len;
          out_left_d = hdr.len;
          pix3_d     = cfg_pix3;
          if (hdr.len == '0)
            state_d = ST_HDR;
          else if (hdr.kind == KIND_VIDEO)
            state_d = (hdr.len >= {{PAD_B{1'b0}}, pb_new}) ? ST_VID : ST_SKIP;
          else if (hdr.kind == KIND_ANC)
            state_d = ST_ANC;
          else
            state_d = ST_SKIP;
        end
      end
      ST_VID: begin
        if (in_fire)  in_left_d  = in_left_q - nb_w;
        if (vid_fire) out_left_d = out_left_q - pb_w;
        if (vid_fire && vid_last)
          state_d = (in_left_d == '0) ? ST_HDR : ST_SKIP;
      end
      ST_ANC, ST_SKIP: begin
        if (in_fire) begin
          in_left_d = in_left_q - nb_w;
          if (word_last) state_d = ST_HDR;
        end
      end
      default: state_d = ST_HDR;
    endcase
  end

  assign en = in_fire || vid_fire;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q    <= ST_HDR;
      in_left_q  <= '0;
      out_left_q <= '0;
      pix3_q     <= 1'b0;
    end else if (en) begin
      state_q    <= state_d;
      in_left_q  <= in_left_d;
      out_left_q <= out_left_d;
      pix3_q     <= pix3_d;
    end
  end

  avc_pix_pack u_pack (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr   (pack_clr),
    .load  (pack_load),
    .word  (in_data),
    .nb    (nb),
    .pop   (vid_fire),
    .pix3  (pix3_q),
    .cnt   (cnt),
    .pixel (vid_pixel)
  );

  avc_seq_check u_seq (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .hdr_fire (hdr_fire),
    .idx      (hdr.idx),
    .kind_bad (kind_bad),
    .err_kind (err_kind),
    .err_seq  (err_seq)
  );

endmodule

// File: rtl/avc_demux_chk.sv
module avc_demux_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        vid_valid,
  input logic        vid_ready,
  input logic [23:0] vid_pixel,
  input logic        vid_last,
  input logic        anc_valid,
  input logic        anc_last,
  input logic [3:0]  anc_be,
  input logic        err_kind,
  input logic        err_seq
);

  // R2
  no_dual_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vid_valid && anc_valid));

  // R9
  vid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_valid && !vid_ready) |=> (vid_valid && $stable(vid_pixel) && $stable(vid_last)));

  // R6
  anc_be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    anc_valid |-> (anc_be == 4'h1 || anc_be == 4'h3 || anc_be == 4'h7 || anc_be == 4'hF));

  // R6
  anc_full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (anc_valid && !anc_last) |-> (anc_be == 4'hF));

  // R7
  err_kind_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_kind |=> err_kind);

  // R8
  err_seq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_seq |=> err_seq);

endmodule

bind avc_demux avc_demux_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .vid_valid (vid_valid),
  .vid_ready (vid_ready),
  .vid_pixel (vid_pixel),
  .vid_last  (vid_last),
  .anc_valid (anc_valid),
  .anc_last  (anc_last),
  .anc_be    (anc_be),
  .err_kind  (err_kind),
  .err_seq   (err_seq)
);

// File: tb/avc_demux_test.sv
module avc_demux_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_pix3;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic        vid_valid, vid_ready, vid_last;
  logic [23:0] vid_pixel;
  logic        anc_valid, anc_ready, anc_last;
  logic [31:0] anc_data;
  logic [3:0]  anc_be;
  logic        err_kind, err_seq;

  int  tests = 0;
  int  fails = 0;
  bit  finished = 0;
  bit  bp_on = 0;
  bit  gaps_on = 0;

  logic [24:0] vq[$];
  string       vt[$];
  logic [36:0] aq[$];
  string       at[$];

  bit          hold_pend = 0;
  logic [24:0] hold_val;

  always #4 clk = ~clk;

  avc_demux uut (
    .clk(clk), .rst_n(rst_n), .cfg_pix3(cfg_pix3),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .vid_valid(vid_valid), .vid_ready(vid_ready), .vid_pixel(vid_pixel), .vid_last(vid_last),
    .anc_valid(anc_valid), .anc_ready(anc_ready), .anc_data(anc_data), .anc_be(anc_be),
    .anc_last(anc_last), .err_kind(err_kind), .err_seq(err_seq)
  );

  function automatic logic [7:0] bt(input int seed, input int i);
    return 8'(seed * 29 + i * 11 + (i >> 3));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put_word(input logic [31:0] w);
    bit ok;
    ok = 0;
    in_data  = w;
    in_valid = 1'b1;
    while (!ok) begin
      @(negedge clk);
      ok = in_ready;
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
    if (gaps_on && ($urandom % 3 == 0)) begin
      @(posedge clk);
      #1;
    end
  endtask

  // driver: pushes the expected items, then sends header and payload
  task automatic send(input logic [7:0] kind, input logic [7:0] idx, input int len,
                      input int seed, input bit p3, input string tag);
    int pb, np, nw, rem;
    cfg_pix3 = p3;
    nw = (len + 3) / 4;
    if (kind == 8'h01) begin
      pb = p3 ? 3 : 1;
      np = len / pb;
      for (int k = 0; k < np; k++) begin
        if (p3) vq.push_back({(k == np - 1), bt(seed, 3*k+2), bt(seed, 3*k+1), bt(seed, 3*k)});
        else    vq.push_back({(k == np - 1), 16'h0000, bt(seed, k)});
        vt.push_back(tag);
      end
    end else if (kind == 8'h02) begin
      rem = len % 4;
      for (int j = 0; j < nw; j++) begin
        logic [3:0] be;
        be = (j == nw - 1 && rem != 0) ? 4'((1 << rem) - 1) : 4'hF;
        aq.push_back({(j == nw - 1), be,
                      bt(seed, 4*j+3), bt(seed, 4*j+2), bt(seed, 4*j+1), bt(seed, 4*j)});
        at.push_back(tag);
      end
    end
    put_word({16'(len), idx, kind});
    for (int j = 0; j < nw; j++)
      put_word({bt(seed, 4*j+3), bt(seed, 4*j+2), bt(seed, 4*j+1), bt(seed, 4*j)});
  endtask

  task automatic drain();
    int w;
    w = 0;
    while ((vq.size() != 0 || aq.size() != 0) && w < 5000) begin
      @(posedge clk);
      w++;
    end
    repeat (6) @(posedge clk);
    #1;
  endtask

  // ready drivers
  initial begin
    vid_ready = 1'b1;
    anc_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      vid_ready = bp_on ? ($urandom % 3 != 0) : 1'b1;
      anc_ready = bp_on ? ($urandom % 3 != 0) : 1'b1;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (hold_pend) begin
        // R9 stalled pixel must stay put
        chk(vid_valid && {vid_last, vid_pixel} == hold_val, "R9", "stalled pixel changed",
            {vid_valid, vid_last, vid_pixel}, {1'b1, hold_val});
      end
      hold_pend = vid_valid && !vid_ready;
      hold_val  = {vid_last, vid_pixel};
      if (vid_valid && vid_ready) begin
        if (vq.size() == 0) begin
          chk(0, "R2", "unexpected pixel", {vid_last, vid_pixel}, 0);
        end else begin
          logic [24:0] e;
          string t;
          e = vq.pop_front();
          t = vt.pop_front();
          chk(vid_pixel == e[23:0], t, "pixel", vid_pixel, e[23:0]);
          chk(vid_last == e[24], "R5", "vid_last", vid_last, e[24]);
        end
      end
      if (anc_valid && anc_ready) begin
        if (aq.size() == 0) begin
          chk(0, "R2", "unexpected ancillary word", anc_data, 0);
        end else begin
          logic [36:0] e;
          string t;
          e = aq.pop_front();
          t = at.pop_front();
          chk(anc_data == e[31:0], t, "anc_data", anc_data, e[31:0]);
          chk(anc_be == e[35:32], "R6", "anc_be", anc_be, e[35:32]);
          chk(anc_last == e[36], "R6", "anc_last", anc_last, e[36]);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] ix;
    rst_n    = 1'b0;
    cfg_pix3 = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(!vid_valid && !anc_valid, "R10", "valids in reset", {vid_valid, anc_valid}, 0);
    chk(!err_kind && !err_seq, "R10", "flags in reset", {err_kind, err_seq}, 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    ix = 8'hFC;
    // R3 one-byte pixels
    send(8'h01, ix, 10, 3, 1'b0, "R3"); ix++;
    // R4 three-byte pixels, exact and with leftovers
    send(8'h01, ix, 12, 5, 1'b1, "R4"); ix++;
    send(8'h01, ix, 11, 6, 1'b1, "R4"); ix++;
    send(8'h01, ix, 13, 7, 1'b1, "R4"); ix++;   // index wraps 0xFF -> 0x00 here
    // R6 ancillary remainders
    send(8'h02, ix, 7, 8, 1'b0, "R6"); ix++;
    send(8'h02, ix, 8, 9, 1'b0, "R6"); ix++;
    send(8'h02, ix, 1, 10, 1'b0, "R6"); ix++;
    // R4 too short for a pixel, R1 zero length
    send(8'h01, ix, 2, 11, 1'b1, "R4"); ix++;
    send(8'h02, ix, 0, 12, 1'b0, "R1"); ix++;
    send(8'h01, ix, 5, 13, 1'b0, "R1"); ix++;
    drain();

    // R9 backpressure and input gaps, containers back to back
    bp_on = 1; gaps_on = 1;
    send(8'h01, ix, 40, 14, 1'b0, "R9"); ix++;
    send(8'h02, ix, 30, 15, 1'b0, "R9"); ix++;
    send(8'h01, ix, 61, 16, 1'b1, "R9"); ix++;
    send(8'h02, ix, 5, 17, 1'b0, "R9"); ix++;
    send(8'h01, ix, 9, 18, 1'b1, "R9"); ix++;
    drain();
    bp_on = 0; gaps_on = 0;
    repeat (3) @(posedge clk);
    #1;

    chk(!err_seq, "R8", "err_seq after in-order indices incl. wrap", err_seq, 0);
    chk(!err_kind, "R7", "err_kind before unknown kind", err_kind, 0);

    // R7 unknown kind: consumed, no output, flag set
    send(8'h07, ix, 9, 19, 1'b0, "R7"); ix++;
    drain();
    chk(err_kind, "R7", "err_kind after unknown kind", err_kind, 1);
    chk(vq.size() == 0 && aq.size() == 0, "R7", "no output from skipped container", 0, 0);
    // R1 framing recovered after the skip
    send(8'h01, ix, 6, 20, 1'b1, "R1"); ix++;
    drain();
    chk(!err_seq, "R8", "err_seq still clear", err_seq, 0);

    // R8 index gap
    ix = ix + 8'd3;
    send(8'h02, ix, 4, 21, 1'b0, "R6"); ix++;
    drain();
    chk(err_seq, "R8", "err_seq after index gap", err_seq, 1);
    send(8'h02, ix, 3, 22, 1'b0, "R6"); ix++;
    drain();
    chk(err_seq, "R8", "err_seq sticky", err_seq, 1);
    chk(err_kind, "R7", "err_kind sticky", err_kind, 1);
    chk(!vid_valid && !anc_valid, "R2", "idle outputs", {vid_valid, anc_valid}, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule